// File: doc/BRIEF.md
# Region/Line Coherence Directory Set

This block is one set of a coherence directory that can track sharers at two granularities. A coarse entry follows a whole aligned group of 16 consecutive cache blocks that all see the same sharer vector. A fine entry follows a single block whose sharers have drifted away from its group's vector. Each way stores a grain flag, a group tag, a block-in-group offset and a sharer vector. Fine entries are indexed by the group address, so a block's coarse and fine entries always sit side by side in this set. When both match a block, the fine entry is the one that answers.

The lookup is combinational on `addr_i`. A lookup reports whether the block hit, whether the answer came from a fine entry, and the sharer vector that governs the block. The block also accepts two kinds of command, applied at the clock edge:
- An update writes a new sharer vector for a block. It creates a coarse entry, splits off a fine entry, rewrites a fine entry or folds one back into its group, whichever fits.
- A flush drops a group's coarse entry together with all of that group's fine entries.

When a flush or a forced replacement removes a group, the union of the removed sharers is reported for one cycle so that the caller can send invalidations.

Top module: `mgdir_set`

## Requirements
- R1: `shr_o` gives the governing sharer vector for the block on `addr_i`. `hit_o` is 1 when any entry matches. `line_hit_o` is 1 only when a fine entry matches. On a miss, `hit_o`, `line_hit_o` and `shr_o` are all 0.
- R2: When a fine entry and its coarse entry both match, `line_hit_o` is 1 and `shr_o` carries the fine entry's vector.
- R3: A coarse entry matches every block whose address bits above the low 4 offset bits equal its tag. It matches no block of another group. A fine entry also compares the low 4 bits.
- R4: `op_i`=1 (update) on a block with no matching entry creates a coarse entry holding `shr_i`. The entry takes the lowest-numbered empty way.
- R5: An update on a block that only its coarse entry covers, with `shr_i` different from that entry's vector, creates a fine entry holding `shr_i`. The coarse entry and the other blocks of the group keep their vector.
- R6: An update on a block with a fine entry rewrites that entry's vector. If `shr_i` equals the coarse entry's vector, the fine entry is freed instead, and the block reads the group's vector afterwards.
- R7: An update on a block that only its coarse entry covers, with `shr_i` equal to that entry's vector, creates no fine entry.
- R8: `op_i`=2 (flush) on a block whose group has a coarse entry removes that entry and all of the group's fine entries. In the next cycle `ev_valid_o`=1, `ev_region_o` is the group tag (address bits above the low 4), and `ev_shr_o` is the OR of every removed vector. A flush of an absent group changes nothing, and `ev_valid_o` stays 0.
- R9: An update that needs a new entry when no way is empty picks a victim: the lowest-numbered coarse entry of a group other than the block's own. The victim group is removed and reported as in R8, and the new entry takes the victim's way.
- R10: If no such victim exists, the update has no effect and `drop_o` is 1 in the next cycle.
- R11: After reset every way is empty, so every lookup misses, and `ev_valid_o` and `drop_o` are 0. `op_i` values 0 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Command: 0 none, 1 update, 2 flush group, 3 none |
| addr_i | input | ADDR_W | Block address (lookup and command target) |
| shr_i | input | SHR_W | New sharer vector for an update |
| hit_o | output | 1 | Some entry governs the block |
| line_hit_o | output | 1 | The governing entry is a fine entry |
| shr_o | output | SHR_W | Governing sharer vector |
| ev_valid_o | output | 1 | A group was removed by the previous command |
| ev_region_o | output | ADDR_W-4 | Tag of the removed group |
| ev_shr_o | output | SHR_W | Union of the removed sharer vectors |
| drop_o | output | 1 | The previous update found neither an empty way nor a victim |

## Verification
The bench targets the following corner cases, each with the fault it would expose:
- A block covered by both kinds of entry. A design that ranked the coarse entry first would return the group vector there.
- An update that restores the group's vector. A design that skipped the fold-back would leave a stale fine entry with `line_hit_o` still high.
- A full set holding a single group. Here a careless victim choice would evict the very group being split, and a design that missed the case would write over a live way instead of raising `drop_o`.
- A flush of a group with several split blocks. This checks that the reported vector is the union over all removed ways and not the coarse entry's vector alone.

// File: rtl/mgdir_pkg.sv
package mgdir_pkg;
   typedef enum logic [1:0] {
      OP_NONE   = 2'd0,
      OP_UPDATE = 2'd1,
      OP_FLUSH  = 2'd2,
      OP_NONE2  = 2'd3
   } dir_op_e;
endpackage

// File: rtl/mgdir_first.sv
// Picks one set bit of req_i as a one-hot vector; scan direction is a parameter.
module mgdir_first #(
   parameter int N         = 8,
   parameter bit HIGH_WINS = 1'b0
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] oh_o,
   output logic         any_o
);
   if (N < 1) begin : g_bad_n
      $error("mgdir_first: N must be at least 1");
   end

   assign any_o = |req_i;

   if (HIGH_WINS) begin : g_high
      always_comb begin
         oh_o = '0;
         for (int i = 0; i < N; i++)
            if (req_i[i]) oh_o = N'(1) << i;
      end
   end else begin : g_low
      always_comb begin
         oh_o = '0;
         for (int i = N - 1; i >= 0; i--)
            if (req_i[i]) oh_o = N'(1) << i;
      end
   end
endmodule

// File: rtl/mgdir_tagcmp.sv
// Per-way match of the group tag and, for fine entries, the block offset.
module mgdir_tagcmp #(
   parameter int WAYS  = 8,
   parameter int TAG_W = 8,
   parameter int OFF_W = 4
) (
   input  logic [WAYS-1:0]             v_i,
   input  logic [WAYS-1:0]             g_i,
   input  logic [WAYS-1:0][TAG_W-1:0]  tag_i,
   input  logic [WAYS-1:0][OFF_W-1:0]  off_i,
   input  logic [TAG_W-1:0]            a_tag_i,
   input  logic [OFF_W-1:0]            a_off_i,
   output logic [WAYS-1:0]             rhit_o,
   output logic [WAYS-1:0]             lhit_o,
   output logic [WAYS-1:0]             same_o
);
   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign same_o[w] = (tag_i[w] == a_tag_i);
      assign rhit_o[w] = v_i[w] & ~g_i[w] & same_o[w];
      assign lhit_o[w] = v_i[w] & g_i[w] & same_o[w] & (off_i[w] == a_off_i);
   end
endmodule

// File: rtl/mgdir_set.sv
module mgdir_set
   import mgdir_pkg::*;
#(
   parameter int WAYS     = 8,
   parameter int ADDR_W   = 12,
   parameter int SHR_W    = 16,
   parameter int REG_BLKS = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [1:0]                   op_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [SHR_W-1:0]             shr_i,
   output logic                         hit_o,
   output logic                         line_hit_o,
   output logic [SHR_W-1:0]             shr_o,
   output logic                         ev_valid_o,
   output logic [ADDR_W-$clog2(REG_BLKS)-1:0] ev_region_o,
   output logic [SHR_W-1:0]             ev_shr_o,
   output logic                         drop_o
);
   localparam int OFF_W = $clog2(REG_BLKS);
   localparam int TAG_W = ADDR_W - OFF_W;

   if (REG_BLKS < 2 || (REG_BLKS & (REG_BLKS - 1)) != 0) begin : g_bad_blks
      $error("mgdir_set: REG_BLKS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("mgdir_set: ADDR_W must exceed the offset width");
   end
   if (WAYS < 2) begin : g_bad_ways
      $error("mgdir_set: WAYS must be at least 2");
   end

   // way state
   logic [WAYS-1:0]            v_q, g_q, v_d, g_d;
   logic [WAYS-1:0][TAG_W-1:0] tag_q, tag_d;
   logic [WAYS-1:0][OFF_W-1:0] off_q, off_d;
   logic [WAYS-1:0][SHR_W-1:0] shr_q, shr_d;

   logic [TAG_W-1:0] a_tag;
   logic [OFF_W-1:0] a_off;
   assign a_tag = addr_i[ADDR_W-1:OFF_W];
   assign a_off = addr_i[OFF_W-1:0];

   logic [WAYS-1:0] rhit, lhit, same;
   mgdir_tagcmp #(.WAYS(WAYS), .TAG_W(TAG_W), .OFF_W(OFF_W)) u_cmp (
      .v_i(v_q), .g_i(g_q), .tag_i(tag_q), .off_i(off_q),
      .a_tag_i(a_tag), .a_off_i(a_off),
      .rhit_o(rhit), .lhit_o(lhit), .same_o(same)
   );

   logic [WAYS-1:0] free_oh, vic_oh;
   logic            free_any, vic_any;
   mgdir_first #(.N(WAYS), .HIGH_WINS(1'b0)) u_free (
      .req_i(~v_q), .oh_o(free_oh), .any_o(free_any)
   );
   mgdir_first #(.N(WAYS), .HIGH_WINS(1'b0)) u_vic (
      .req_i(v_q & ~g_q & ~same), .oh_o(vic_oh), .any_o(vic_any)
   );

   // lookup: fine entry outranks coarse entry
   logic [SHR_W-1:0] r_shr, l_shr;
   logic [TAG_W-1:0] vic_tag;
   logic             any_r, any_l;
   always_comb begin
      r_shr   = '0;
      l_shr   = '0;
      vic_tag = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (rhit[w])   r_shr   |= shr_q[w];
         if (lhit[w])   l_shr   |= shr_q[w];
         if (vic_oh[w]) vic_tag |= tag_q[w];
      end
   end
   assign any_r      = |rhit;
   assign any_l      = |lhit;
   assign hit_o      = any_r | any_l;
   assign line_hit_o = any_l;
   assign shr_o      = any_l ? l_shr : r_shr;

   // command decode and next state
   dir_op_e          op;
   logic             do_alloc, alloc_line, do_flush, ev_d, drop_d;
   logic [TAG_W-1:0] fl_tag, evr_d;
   logic [SHR_W-1:0] evs_d;
   logic [WAYS-1:0]  tgt;
   assign op = dir_op_e'(op_i);

   always_comb begin
      v_d = v_q;  g_d = g_q;  tag_d = tag_q;  off_d = off_q;  shr_d = shr_q;
      do_alloc   = 1'b0;
      alloc_line = 1'b0;
      do_flush   = 1'b0;
      fl_tag     = a_tag;
      drop_d     = 1'b0;
      tgt        = free_oh;
      unique case (op)
         OP_UPDATE: begin
            if (any_l) begin
               for (int w = 0; w < WAYS; w++)
                  if (lhit[w]) begin
                     if (any_r && shr_i == r_shr) v_d[w]   = 1'b0;
                     else                         shr_d[w] = shr_i;
                  end
            end else if (any_r) begin
               if (shr_i != r_shr) begin
                  do_alloc   = 1'b1;
                  alloc_line = 1'b1;
               end
            end else begin
               do_alloc = 1'b1;
            end
         end
         OP_FLUSH: do_flush = any_r;
         default: ;
      endcase
      if (do_alloc && !free_any) begin
         if (vic_any) begin
            do_flush = 1'b1;
            fl_tag   = vic_tag;
            tgt      = vic_oh;
         end else begin
            do_alloc = 1'b0;
            drop_d   = 1'b1;
         end
      end
      ev_d  = do_flush;
      evr_d = fl_tag;
      evs_d = '0;
      if (do_flush)
         for (int w = 0; w < WAYS; w++)
            if (v_q[w] && tag_q[w] == fl_tag) begin
               v_d[w] = 1'b0;
               evs_d |= shr_q[w];
            end
      if (do_alloc)
         for (int w = 0; w < WAYS; w++)
            if (tgt[w]) begin
               v_d[w]   = 1'b1;
               g_d[w]   = alloc_line;
               tag_d[w] = a_tag;
               off_d[w] = a_off;
               shr_d[w] = shr_i;
            end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q         <= '0;
         g_q         <= '0;
         tag_q       <= '0;
         off_q       <= '0;
         shr_q       <= '0;
         ev_valid_o  <= 1'b0;
         ev_region_o <= '0;
         ev_shr_o    <= '0;
         drop_o      <= 1'b0;
      end else begin
         v_q         <= v_d;
         g_q         <= g_d;
         tag_q       <= tag_d;
         off_q       <= off_d;
         shr_q       <= shr_d;
         ev_valid_o  <= ev_d;
         ev_region_o <= evr_d;
         ev_shr_o    <= evs_d;
         drop_o      <= drop_d;
      end
   end
endmodule

// File: rtl/mgdir_set_chk.sv
module mgdir_set_chk #(
   parameter int WAYS   = 8,
   parameter int ADDR_W = 12,
   parameter int SHR_W  = 16,
   parameter int TAG_W  = 8,
   parameter int OFF_W  = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [1:0]                  op_i,
   input logic [ADDR_W-1:0]           addr_i,
   input logic [SHR_W-1:0]            shr_i,
   input logic                        hit_o,
   input logic [SHR_W-1:0]            shr_o,
   input logic                        ev_valid_o,
   input logic                        drop_o,
   input logic [WAYS-1:0]             v_q,
   input logic [WAYS-1:0]             g_q,
   input logic [WAYS-1:0][TAG_W-1:0]  tag_q,
   input logic [WAYS-1:0][OFF_W-1:0]  off_q
);
   logic [WAYS-1:0] orphan;
   logic            dup_region, dup_line;
   always_comb begin
      orphan     = '0;
      dup_region = 1'b0;
      dup_line   = 1'b0;
      for (int i = 0; i < WAYS; i++) begin
         if (v_q[i] && g_q[i]) begin
            orphan[i] = 1'b1;
            for (int j = 0; j < WAYS; j++)
               if (v_q[j] && !g_q[j] && tag_q[j] == tag_q[i]) orphan[i] = 1'b0;
         end
         for (int j = i + 1; j < WAYS; j++) begin
            if (v_q[i] && v_q[j] && !g_q[i] && !g_q[j] && tag_q[i] == tag_q[j])
               dup_region = 1'b1;
            if (v_q[i] && v_q[j] && g_q[i] && g_q[j] && tag_q[i] == tag_q[j]
                && off_q[i] == off_q[j])
               dup_line = 1'b1;
         end
      end
   end

   AST_ONE_REGION_PER_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      !dup_region);                                                            // R4
   AST_ONE_LINE_PER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      !dup_line);                                                              // R5
   AST_NO_ORPHAN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      orphan == '0);                                                           // R8
   AST_UPDATE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd1) |=> ((addr_i != $past(addr_i)) || drop_o
                          || (hit_o && shr_o == $past(shr_i))));               // R6
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 2'd2) |=> ((addr_i != $past(addr_i)) || !hit_o));               // R8
   AST_EVENT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid_o |-> ($past(op_i) == 2'd1 || $past(op_i) == 2'd2));            // R9
   AST_DROP_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      drop_o |-> ($past(&v_q) && $past(op_i) == 2'd1));                        // R10
endmodule

bind mgdir_set mgdir_set_chk #(
   .WAYS(WAYS), .ADDR_W(ADDR_W), .SHR_W(SHR_W), .TAG_W(TAG_W), .OFF_W(OFF_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .shr_i(shr_i),
   .hit_o(hit_o), .shr_o(shr_o), .ev_valid_o(ev_valid_o), .drop_o(drop_o),
   .v_q(v_q), .g_q(g_q), .tag_q(tag_q), .off_q(off_q)
);

// File: tb/mgdir_set_tb.sv
module mgdir_set_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [11:0] addr_i = '0;
   logic [15:0] shr_i = '0;
   logic        hit_o, line_hit_o, ev_valid_o, drop_o;
   logic [15:0] shr_o, ev_shr_o;
   logic [7:0]  ev_region_o;

   mgdir_set u_dut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .addr_i(addr_i), .shr_i(shr_i),
      .hit_o(hit_o), .line_hit_o(line_hit_o), .shr_o(shr_o),
      .ev_valid_o(ev_valid_o), .ev_region_o(ev_region_o), .ev_shr_o(ev_shr_o),
      .drop_o(drop_o)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   // reference model of the set
   logic        m_v[NW], m_g[NW];
   logic [7:0]  m_tag[NW];
   logic [3:0]  m_off[NW];
   logic [15:0] m_shr[NW];
   logic        x_ev = 1'b0, x_drop = 1'b0;
   logic [7:0]  x_evr = '0;
   logic [15:0] x_evs = '0;
   string       ev_label = "R11";

   function automatic void model_find(input logic [11:0] a, output int ri, output int li);
      ri = -1; li = -1;
      for (int w = 0; w < NW; w++) begin
         if (m_v[w] && !m_g[w] && m_tag[w] == a[11:4]) ri = w;
         if (m_v[w] && m_g[w] && m_tag[w] == a[11:4] && m_off[w] == a[3:0]) li = w;
      end
   endfunction

   function automatic void model_flush(input logic [7:0] t);
      x_ev = 1'b1; x_evr = t; x_evs = '0;
      for (int w = 0; w < NW; w++)
         if (m_v[w] && m_tag[w] == t) begin
            m_v[w] = 1'b0;
            x_evs |= m_shr[w];
         end
   endfunction

   function automatic void model_alloc(input logic line, input logic [11:0] a, input logic [15:0] s);
      int tw = -1;
      for (int w = NW - 1; w >= 0; w--) if (!m_v[w]) tw = w;
      if (tw < 0) begin
         for (int w = NW - 1; w >= 0; w--)
            if (m_v[w] && !m_g[w] && m_tag[w] != a[11:4]) tw = w;
         if (tw < 0) begin
            x_drop = 1'b1;
            return;
         end
         model_flush(m_tag[tw]);
      end
      m_v[tw] = 1'b1; m_g[tw] = line; m_tag[tw] = a[11:4];
      m_off[tw] = a[3:0]; m_shr[tw] = s;
   endfunction

   function automatic void model_apply(input logic [1:0] op, input logic [11:0] a, input logic [15:0] s);
      int ri, li;
      model_find(a, ri, li);
      x_ev = 1'b0; x_drop = 1'b0; x_evs = '0;
      if (op == 2'd1) begin
         if (li >= 0) begin
            if (ri >= 0 && s == m_shr[ri]) m_v[li] = 1'b0;
            else m_shr[li] = s;
         end else if (ri >= 0) begin
            if (s != m_shr[ri]) model_alloc(1'b1, a, s);
         end else begin
            model_alloc(1'b0, a, s);
         end
      end else if (op == 2'd2 && ri >= 0) begin
         model_flush(a[11:4]);
      end
   endfunction

   task automatic step(input logic [1:0] op, input logic [11:0] a, input logic [15:0] s,
                       input string lbl);
      int ri, li;
      logic eh, el;
      logic [15:0] es;
      @(negedge clk);
      op_i = op; addr_i = a; shr_i = s;
      #1;
      model_find(a, ri, li);
      eh = (ri >= 0) || (li >= 0);
      el = (li >= 0);
      es = (li >= 0) ? m_shr[li] : ((ri >= 0) ? m_shr[ri] : 16'h0);
      n_chk++;
      if (hit_o !== eh || line_hit_o !== el || shr_o !== es) begin
         n_bad++;
         $display("FAIL %s lookup addr=%h: actual hit=%b line=%b shr=%h expected hit=%b line=%b shr=%h",
                  lbl, a, hit_o, line_hit_o, shr_o, eh, el, es);
      end
      n_chk++;
      if (ev_valid_o !== x_ev || drop_o !== x_drop ||
          (x_ev && (ev_region_o !== x_evr || ev_shr_o !== x_evs))) begin
         n_bad++;
         $display("FAIL %s event: actual ev=%b reg=%h shr=%h drop=%b expected ev=%b reg=%h shr=%h drop=%b",
                  ev_label, ev_valid_o, ev_region_o, ev_shr_o, drop_o, x_ev, x_evr, x_evs, x_drop);
      end
      model_apply(op, a, s);
      ev_label = lbl;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual no finish expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] pool[4];
      pool[0] = 16'h0001; pool[1] = 16'h0003; pool[2] = 16'h8000; pool[3] = 16'h00F0;
      for (int w = 0; w < NW; w++) begin
         m_v[w] = 1'b0; m_g[w] = 1'b0; m_tag[w] = '0; m_off[w] = '0; m_shr[w] = '0;
      end
      void'($urandom(32'd20240607));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: empty after reset
      step(2'd0, 12'h053, 16'h0000, "R11");
      step(2'd3, 12'h053, 16'hFFFF, "R11");
      // R4, R3, R1: group creation and coverage
      step(2'd1, 12'h053, 16'h0003, "R4");
      step(2'd0, 12'h059, 16'h0000, "R3");
      step(2'd0, 12'h063, 16'h0000, "R3");
      step(2'd0, 12'h05F, 16'h0000, "R1");
      // R5, R2: split off a fine entry
      step(2'd1, 12'h053, 16'h0007, "R5");
      step(2'd0, 12'h053, 16'h0000, "R2");
      step(2'd0, 12'h054, 16'h0000, "R5");
      // R6: rewrite then fold back
      step(2'd1, 12'h053, 16'h0005, "R6");
      step(2'd0, 12'h053, 16'h0000, "R6");
      step(2'd1, 12'h053, 16'h0003, "R6");
      step(2'd0, 12'h053, 16'h0000, "R6");
      // R7: same vector creates nothing
      step(2'd1, 12'h054, 16'h0003, "R7");
      step(2'd0, 12'h054, 16'h0000, "R7");
      // R8: flush with a fine entry, then flush of an absent group
      step(2'd1, 12'h052, 16'h0100, "R8");
      step(2'd2, 12'h05A, 16'h0000, "R8");
      step(2'd0, 12'h052, 16'h0000, "R8");
      step(2'd2, 12'h077, 16'h0000, "R8");
      step(2'd0, 12'h077, 16'h0000, "R8");
      // R10: full set of one group
      step(2'd1, 12'h090, 16'h0001, "R10");
      for (int i = 1; i < 8; i++)
         step(2'd1, {8'h09, 4'(i)}, 16'h0010 << i, "R10");
      step(2'd1, 12'h098, 16'h4000, "R10");
      step(2'd0, 12'h098, 16'h0000, "R10");
      // R9: forced replacement of the only other group
      step(2'd1, 12'h0A0, 16'h2222, "R9");
      step(2'd0, 12'h0A5, 16'h0000, "R9");
      step(2'd0, 12'h091, 16'h0000, "R9");

      // constrained random: 5 groups contend for 8 ways
      for (int n = 0; n < 4000; n++) begin
         int r;
         logic [1:0]  op;
         logic [11:0] a;
         r  = $urandom_range(0, 9);
         op = (r < 6) ? 2'd1 : ((r == 6) ? 2'd2 : 2'd0);
         a  = {8'h20 + 8'($urandom_range(0, 4)), 4'($urandom_range(0, 15))};
         step(op, a, pool[$urandom_range(0, 3)], "R1");
      end
      step(2'd0, 12'h000, 16'h0000, "R9");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule